// File: doc/BRIEF.md
# Byte-Wide Slave Configuration Loader

This block loads a bitstream into a downstream programmable device through its byte-wide slave configuration port. A start request makes it pulse the active-low program line for a set number of system clocks. It then waits until the device's init line reads high again. Only then does it drive the write-select and chip-select lines low and begin moving bytes.

Bytes arrive on a valid/ready stream with a last flag. Each accepted byte goes out on the data pins with exactly one configuration clock pulse, which the block makes by dividing the system clock. After the byte marked last, the block keeps clocking 0xFF filler bytes until the device raises done. If the device pulls init low during loading, or after done, the block enters an error state. It also enters the error state when done has not appeared after a set number of filler bytes.

The configuration clock stays far below the rate at which the device's busy pin matters, so busy is not monitored. The block does not parse the bitstream and does not read anything back.

Top module: `spcfg_loader`

## Requirements
- R1: After reset the block is idle: program, chip-select and write-select pins are high, the configuration clock is low, in_ready is low, and both status outputs are low.
- R2: A start request seen in the idle state drives cfg_prog_n low for exactly PROG_CYCLES system clocks, starting with the clock after the request.
- R3: Once program is released, chip-select and write-select stay high until the synchronised init input reads high; then both go low together.
- R4: Each byte taken on a valid/ready handshake appears on cfg_d and gets exactly one rising edge of cfg_cclk, and bytes keep their stream order. The clock is low for CCLK_HALF system clocks and then high for CCLK_HALF system clocks.
- R5: cfg_d holds its value for at least one system clock before each rising edge of cfg_cclk and for the whole high phase.
- R6: After the byte carrying in_last, 0xFF filler bytes are clocked one at a time until done is seen high at a byte boundary. The block then releases chip-select and write-select and raises load_done.
- R7: init going low while bytes are being clocked, or after load_done, raises load_err. In that state chip-select is high, cfg_cclk is low, and no more bytes are clocked.
- R8: If done has not risen after PAD_LIMIT filler bytes, the block raises load_err without clocking another byte.
- R9: start is ignored unless the block is idle, done or in error. A request during loading causes no program pulse. A request from done or error starts a fresh load.
- R10: in_ready is high only while chip-select is low, the configuration clock is low and no byte is being clocked. While the source stalls, cfg_cclk stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to begin a configuration run |
| in_data | input | 8 | Stream byte |
| in_valid | input | 1 | Stream byte valid |
| in_last | input | 1 | Marks the final bitstream byte |
| in_ready | output | 1 | Block accepts the stream byte this cycle |
| cfg_prog_n | output | 1 | Active-low program pulse to the device |
| cfg_init_n | input | 1 | Device init line (low while clearing or on error) |
| cfg_done | input | 1 | Device done line |
| cfg_cs_n | output | 1 | Active-low chip-select |
| cfg_rdwr_n | output | 1 | Read/write select, low for writes |
| cfg_cclk | output | 1 | Configuration clock |
| cfg_d | output | 8 | Configuration data byte |
| load_done | output | 1 | Configuration finished with done high |
| load_err | output | 1 | Configuration failed (init low or filler timeout) |

## Verification
The bench models the device. It records every byte on a rising configuration clock edge, holds init low for a variable time after the program pulse, and raises done a chosen number of filler bytes after the stream ends. This exposes a loader that starts writing before init returns high, or one that counts the filler bytes wrong by one. Mid-stream stalls and a start request in the middle of loading target two faults: a clock that runs without data, and a restart that wipes a load already under way. An init drop mid-load, an init drop after done, and a device that never raises done must each end in the error state with chip-select released. A loader that hangs or keeps clocking in any of these cases fails its checks.

// File: rtl/spcfg_loader.sv
module spcfg_loader #(
  parameter int PROG_CYCLES = 1000,
  parameter int CCLK_HALF   = 4,
  parameter int PAD_LIMIT   = 65536
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  output logic       in_ready,
  output logic       cfg_prog_n,
  input  logic       cfg_init_n,
  input  logic       cfg_done,
  output logic       cfg_cs_n,
  output logic       cfg_rdwr_n,
  output logic       cfg_cclk,
  output logic [7:0] cfg_d,
  output logic       load_done,
  output logic       load_err
);

  localparam int CNT_MAX = (PROG_CYCLES > PAD_LIMIT) ? PROG_CYCLES : PAD_LIMIT;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam int PW      = $clog2(2 * CCLK_HALF + 1);
  localparam logic [PW-1:0] PH_RISE = PW'(CCLK_HALF);
  localparam logic [PW-1:0] PH_END  = PW'(2 * CCLK_HALF);
  localparam logic [CW-1:0] PROG_LAST = CW'(PROG_CYCLES - 1);
  localparam logic [CW-1:0] PAD_MAX   = CW'(PAD_LIMIT);

  typedef enum logic [2:0] {
    S_IDLE, S_PROG, S_WINIT, S_LOAD, S_PAD, S_DONE, S_ERR
  } ld_state_t;

  ld_state_t      state;
  logic [CW-1:0]  cnt;
  logic [PW-1:0]  ph;
  logic           last_q;
  logic           cclk_q;
  logic [7:0]     d_q;
  logic           init_m, init_s, done_m, done_s;

  logic slot, feeding, can_start;
  assign slot      = (ph == '0);
  assign feeding   = (state == S_LOAD) || (state == S_PAD);
  assign can_start = (state == S_IDLE) || (state == S_DONE) || (state == S_ERR);

  assign in_ready   = (state == S_LOAD) && slot && !last_q && init_s;
  assign cfg_prog_n = (state != S_PROG);
  assign cfg_cs_n   = !feeding;
  assign cfg_rdwr_n = !feeding;
  assign cfg_cclk   = cclk_q;
  assign cfg_d      = d_q;
  assign load_done  = (state == S_DONE);
  assign load_err   = (state == S_ERR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_m <= 1'b1;
      init_s <= 1'b1;
      done_m <= 1'b0;
      done_s <= 1'b0;
    end else begin
      init_m <= cfg_init_n;
      init_s <= init_m;
      done_m <= cfg_done;
      done_s <= done_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      ph     <= '0;
      last_q <= 1'b0;
      cclk_q <= 1'b0;
      d_q    <= '0;
    end else begin
      case (state)
        S_PROG: begin
          if (cnt == PROG_LAST) begin
            state <= S_WINIT;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_WINIT: begin
          if (init_s) state <= S_LOAD;
        end
        S_LOAD, S_PAD: begin
          if (!init_s) begin
            state  <= S_ERR;
            cclk_q <= 1'b0;
            ph     <= '0;
          end else if (slot) begin
            if (state == S_LOAD) begin
              if (last_q) begin
                state <= S_PAD;
              end else if (in_valid) begin
                d_q    <= in_data;
                last_q <= in_last;
                ph     <= PW'(1);
              end
            end else if (done_s) begin
              state <= S_DONE;
            end else if (cnt == PAD_MAX) begin
              state <= S_ERR;
            end else begin
              d_q <= 8'hFF;
              cnt <= cnt + 1'b1;
              ph  <= PW'(1);
            end
          end else begin
            ph     <= (ph == PH_END) ? '0 : ph + 1'b1;
            cclk_q <= (ph >= PH_RISE) && (ph != PH_END);
          end
        end
        default: begin
          cclk_q <= 1'b0;
          ph     <= '0;
          if (start) begin
            state  <= S_PROG;
            cnt    <= '0;
            last_q <= 1'b0;
          end else if (state == S_DONE && !init_s) begin
            state <= S_ERR;
          end
        end
      endcase
    end
  end

  AST_PROG_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_prog_n) |-> ($past(start) && $past(can_start)));  // R9
  AST_CS_AFTER_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_cs_n) |-> ($past(init_s) && $past(state == S_WINIT)));  // R3
  AST_CCLK_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_cclk |-> (!cfg_cs_n && !cfg_rdwr_n && cfg_prog_n));  // R4
  AST_D_BEFORE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_cclk) |-> $stable(cfg_d));  // R5
  AST_D_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cclk && $past(cfg_cclk)) |-> $stable(cfg_d));  // R5
  AST_PAD_IS_FF: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cfg_cclk) && state == S_PAD) |-> (cfg_d == 8'hFF));  // R6
  AST_INIT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_cs_n && !init_s) |=> load_err);  // R7
  AST_READY_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!cfg_cs_n && !cfg_cclk));  // R10

endmodule

// File: tb/test_spcfg_loader.sv
`timescale 1ns/1ps
module test_spcfg_loader;

  localparam int P  = 20;
  localparam int H  = 2;
  localparam int PL = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] in_data = '0;
  logic in_valid = 1'b0, in_last = 1'b0, in_ready;
  logic cfg_prog_n, cfg_init_n = 1'b1, cfg_done;
  logic cfg_cs_n, cfg_rdwr_n, cfg_cclk;
  logic [7:0] cfg_d;
  logic load_done, load_err;

  always #2.5 clk = ~clk;

  spcfg_loader #(.PROG_CYCLES(P), .CCLK_HALF(H), .PAD_LIMIT(PL)) i_spcfg_loader (
    .clk(clk), .rst_n(rst_n), .start(start),
    .in_data(in_data), .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
    .cfg_prog_n(cfg_prog_n), .cfg_init_n(cfg_init_n), .cfg_done(cfg_done),
    .cfg_cs_n(cfg_cs_n), .cfg_rdwr_n(cfg_rdwr_n), .cfg_cclk(cfg_cclk), .cfg_d(cfg_d),
    .load_done(load_done), .load_err(load_err));

  int checks = 0, fails = 0, cyc = 0;
  int n_exp = 0, done_after = 0;
  logic [7:0] bytes [256];
  logic [7:0] cap [256];
  int cap_n = 0;
  logic tgt_done = 1'b0;
  assign cfg_done = tgt_done;

  // device model: captures a byte on each rising configuration clock
  always @(posedge cfg_cclk or negedge cfg_prog_n) begin
    if (!cfg_prog_n) begin
      cap_n    <= 0;
      tgt_done <= 1'b0;
    end else if (!cfg_cs_n && !cfg_rdwr_n) begin
      if (cap_n < 256) cap[cap_n] <= cfg_d;
      if (done_after > 0 && cap_n + 1 == n_exp + done_after) tgt_done <= 1'b1;
      cap_n <= cap_n + 1;
    end
  end

  int plow = 0, pfalls = 0, stab_viol = 0, rdy_viol = 0;
  logic prev_prog = 1'b1, prev_cclk = 1'b0;
  logic [7:0] prev_d = '0;
  always @(negedge clk) begin
    if (!cfg_prog_n) plow <= plow + 1;
    if (prev_prog && !cfg_prog_n) pfalls <= pfalls + 1;
    if (rst_n && cfg_cclk && cfg_d != prev_d) stab_viol <= stab_viol + 1;
    if (rst_n && in_ready && (cfg_cs_n || cfg_cclk)) rdy_viol <= rdy_viol + 1;
    prev_prog <= cfg_prog_n;
    prev_cclk <= cfg_cclk;
    prev_d    <= cfg_d;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_count(input int n, input int pads);
    return n + pads;
  endfunction

  function automatic logic [7:0] exp_byte(input int i, input int n);
    return (i < n) ? bytes[i] : 8'hFF;
  endfunction

  task automatic run_cfg(input int n, input int gap, input int init_dly, input int dafter,
                         input int inject_at, input bit poke, input int exp_pads, input bit exp_err);
    int p0, f0, idx, mism, hold;
    bit poked;
    n_exp = n;
    done_after = dafter;
    for (int i = 0; i < n; i++) bytes[i] = 8'($urandom);
    p0 = plow; f0 = pfalls;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(cfg_prog_n == 1'b0, "R2 prog low after start", cfg_prog_n, 0);
    cfg_init_n = 1'b0;
    for (int k = 0; k < 10000 && !cfg_prog_n; k++) @(negedge clk);
    chk(plow - p0 == P, "R2 prog pulse width", plow - p0, P);
    repeat (init_dly) @(negedge clk);
    chk(cfg_cs_n == 1'b1, "R3 no select before init high", cfg_cs_n, 1);
    cfg_init_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cfg_cs_n == 1'b0 && cfg_rdwr_n == 1'b0, "R3 select after init high",
        {cfg_cs_n, cfg_rdwr_n}, 0);
    idx = 0; poked = 1'b0;
    while (idx < n && !load_err) begin
      @(negedge clk);
      if (inject_at >= 0 && cap_n >= inject_at) begin
        cfg_init_n = 1'b0;
        in_valid = 1'b0;
        break;
      end
      if (poke && !poked && idx == n / 2) begin start = 1'b1; poked = 1'b1; end
      else start = 1'b0;
      in_valid = ($urandom_range(99) >= gap);
      in_data  = bytes[idx];
      in_last  = (idx == n - 1);
      if (in_valid && in_ready) idx++;
    end
    @(negedge clk);
    in_valid = 1'b0; start = 1'b0;
    for (int k = 0; k < 3000 && !load_done && !load_err; k++) @(negedge clk);
    chk(load_err == exp_err, exp_err ? "R8/R7 error flagged" : "R6 done flagged",
        load_err, exp_err);
    chk(load_done == !exp_err, "R6 done status", load_done, !exp_err);
    chk(cfg_cs_n && cfg_rdwr_n && !cfg_cclk, "R6 pins released at end",
        {cfg_cs_n, cfg_rdwr_n, cfg_cclk}, 6);
    if (inject_at < 0) begin
      chk(cap_n == exp_count(n, exp_pads), exp_err ? "R8 filler count at timeout" : "R6 filler count",
          cap_n, exp_count(n, exp_pads));
      mism = 0;
      for (int i = 0; i < cap_n && i < 256; i++) if (cap[i] !== exp_byte(i, n)) mism++;
      chk(mism == 0, "R4 byte order and filler value", mism, 0);
    end else begin
      hold = cap_n;
      repeat (20) @(negedge clk);
      chk(cap_n == hold, "R7 no bytes after init fault", cap_n, hold);
      chk(load_err == 1'b1, "R7 error held", load_err, 1);
      cfg_init_n = 1'b1;
    end
    if (poke) chk(pfalls - f0 == 1, "R9 start ignored while loading", pfalls - f0, 1);
  endtask

  initial begin
    void'($urandom(32'd9137));
    repeat (3) @(negedge clk);
    chk(cfg_prog_n && cfg_cs_n && cfg_rdwr_n && !cfg_cclk && !in_ready && !load_done && !load_err,
        "R1 reset state", {cfg_prog_n, cfg_cs_n, cfg_rdwr_n, cfg_cclk, in_ready, load_done, load_err},
        7'b1110000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cfg_prog_n && !in_ready, "R1 idle after reset", {cfg_prog_n, in_ready}, 2);

    run_cfg(6, 25, 10, 3, -1, 1'b0, 3, 1'b0);
    run_cfg(24, 60, 1, 1, -1, 1'b1, 1, 1'b0);   // R9 restart from done, mid-load start
    run_cfg(4, 0, 3, 0, -1, 1'b0, PL, 1'b1);    // R8 never done
    run_cfg(12, 30, 5, 2, 5, 1'b0, 0, 1'b1);    // R7 from error, init drop mid-load
    run_cfg(1, 0, 2, 2, -1, 1'b0, 2, 1'b0);
    cfg_init_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(load_err == 1'b1 && load_done == 1'b0, "R7 init low after done", load_err, 1);
    cfg_init_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int r = 0; r < 6; r++) begin
      int nn, dd;
      nn = $urandom_range(16, 1);
      dd = $urandom_range(5, 1);
      run_cfg(nn, $urandom_range(70), $urandom_range(8), dd, -1, 1'b0, dd, 1'b0);
    end
    chk(stab_viol == 0, "R5 data stable around clock", stab_viol, 0);
    chk(rdy_viol == 0, "R10 ready only in load slot", rdy_viol, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule